// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block hands the local bus over to an external master on request and takes it back afterwards. The request arrives on an input that may change at any time relative to the clock, so it first passes through a multi-flop synchroniser. Once the synchronised request is seen, the arbiter waits for any bus cycle in progress and for any locked sequence to finish. It then turns off the bus drivers, and only on the following clock does it raise the acknowledge.

The grant lasts for as long as the request stays high. When the request falls, the acknowledge is lowered first, and the drivers come back one clock later, so the two masters never drive the bus at the same time.

While the bus is released, the groups of lines are treated differently:

- The address and byte-enable lines float.
- The data transceivers are switched off.
- The memory/IO and code/interrupt-acknowledge lines keep their last driven level.
- The active-low status, lock and coprocessor-acknowledge lines are forced to logic one.
- The ready input is masked inactive, so a stray ready cannot end a bus cycle.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous active-low reset, including one applied during a grant, returns the block to the owned state. In that state hlda_o=0, hold_active_o=0, addr_oe_o=1 and data_oe_o=1, and this is visible after the next rising edge.
- R2: A request on an idle bus, held high, passes through two synchroniser flops. hold_active_o rises and both output enables fall after the third rising edge following the request, and hlda_o rises after the fourth.
- R3: hlda_o never rises unless the output enables were already low during the previous cycle.
- R4: While cycle_busy_i is high in the owned state, the bus is not released. Release happens one edge after cycle_busy_i falls, provided the request is still high.
- R5: While lock_n_i is low (lock asserted) in the owned state, the bus is not released. Release happens one edge after lock_n_i returns high.
- R6: hlda_o stays high for as long as the synchronised request is high. Once the request falls, hlda_o falls after the third rising edge. The output enables return one edge after hlda_o falls and are never high while hlda_o is high.
- R7: Whenever hold_active_o=1, stat_n_o, lock_n_o and peack_n_o are all ones, whatever their inputs. In the owned state they pass their inputs through.
- R8: Whenever hold_active_o=1, mio_o and cod_o hold the values that mio_i and cod_i had in the last owned cycle. In the owned state they follow their inputs.
- R9: Whenever hold_active_o=1, ready_n_o=1 (not ready) regardless of ready_n_i. In the owned state ready_n_o equals ready_n_i.
- R10: A request that has fallen again by the time the release state is reached makes the block return to the owned state without raising hlda_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req_i | input | 1 | Asynchronous bus request from the external master, active high |
| cycle_busy_i | input | 1 | A local bus cycle is in progress |
| lock_n_i | input | 1 | Active-low lock from the bus controller |
| ready_n_i | input | 1 | Active-low ready from the bus |
| stat_n_i | input | STAT_W | Active-low bus status lines from the bus controller |
| peack_n_i | input | 1 | Active-low coprocessor operand acknowledge |
| mio_i | input | 1 | Memory/IO select from the bus controller |
| cod_i | input | 1 | Code/interrupt-acknowledge select from the bus controller |
| hlda_o | output | 1 | Hold acknowledge, active high, always driven |
| hold_active_o | output | 1 | To the bus controller: the bus is released or being handed over |
| addr_oe_o | output | 1 | Output enable for the address and byte-enable drivers |
| data_oe_o | output | 1 | Output enable for the data transceivers |
| stat_n_o | output | STAT_W | Status lines, forced to ones during hold |
| lock_n_o | output | 1 | Lock line, forced to one during hold |
| peack_n_o | output | 1 | Coprocessor acknowledge, forced to one during hold |
| mio_o | output | 1 | Memory/IO select, holds its last level during hold |
| cod_o | output | 1 | Code/interrupt-acknowledge select, holds its last level during hold |
| ready_n_o | output | 1 | Ready to the bus cycle logic, masked inactive during hold |

## Verification
The state register sits behind a two-flop synchroniser. Counting from the clock edge at which a new request level is first captured, hold_active_o and the enables change after the third rising edge and hlda_o after the fourth. A busy or lock release takes effect one edge after it is removed. The forced status, masked ready and held control lines are combinational from the state, so they are valid in the same cycle as hold_active_o.

The bench drives inputs on the falling edge and applies one vector per clock. It samples on the next falling edge, so every expected value in the vector table already includes these latencies cycle by cycle. The directed tests for held levels and for reset in mid-grant count edges the same way.

// File: rtl/bha_pkg.sv
// Package: shared state type for the bus hold arbiter.
// Assumes: four states, encoded as two bits.
package bha_pkg;
    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,  // local master drives the bus
        ST_RELEASE = 2'd1,  // drivers off, acknowledge not yet given
        ST_GRANT   = 2'd2,  // acknowledge high, external master owns bus
        ST_RECLAIM = 2'd3   // acknowledge low, drivers still off
    } bha_state_e;
endpackage

// File: rtl/bha_sync.sv
// Module: multi-flop synchroniser for an asynchronous level input.
// Assumes: STAGES >= 2; the input is a level that is held for several clocks.
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_i};
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/bha_fsm.sv
// Module: handover sequencer. It releases the drivers, then acknowledges,
//         then withdraws the acknowledge, then reclaims the drivers.
// Assumes: req_i is already synchronous; busy_i and lock_n_i come from the
//          local bus controller.
module bha_fsm
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    input  logic lock_n_i,
    output logic hlda_o,
    output logic own_o
);
    bha_state_e st_q, st_d;

    // Next-state selection for the handover sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OWN:     if (req_i && !busy_i && lock_n_i) st_d = ST_RELEASE;
            ST_RELEASE: st_d = req_i ? ST_GRANT : ST_OWN;
            ST_GRANT:   if (!req_i) st_d = ST_RECLAIM;
            ST_RECLAIM: st_d = ST_OWN;
            default:    st_d = ST_OWN;
        endcase
    end

    // State register with synchronous reset to the owned state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OWN;
        else        st_q <= st_d;
    end

    assign hlda_o = (st_q == ST_GRANT);
    assign own_o  = (st_q == ST_OWN);

    assert_wait_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && busy_i) |=> own_o);
    assert_wait_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !lock_n_i) |=> own_o);
    assert_grant_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda_o && req_i) |=> hlda_o);
endmodule

// File: rtl/bha_outmux.sv
// Module: per-group line conditioning during hold. It forces the active-low
//         status lines high, keeps the select lines at their last owned level
//         and masks ready.
// Assumes: own_i is high exactly when the local master owns the bus.
module bha_outmux #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_i,
    input  logic [STAT_W-1:0] stat_n_i,
    input  logic              lock_n_i,
    input  logic              peack_n_i,
    input  logic              mio_i,
    input  logic              cod_i,
    input  logic              ready_n_i,
    output logic [STAT_W-1:0] stat_n_o,
    output logic              lock_n_o,
    output logic              peack_n_o,
    output logic              mio_o,
    output logic              cod_o,
    output logic              ready_n_o
);
    logic mio_q, cod_q;

    // Capture the select levels while owned so they can be held during hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mio_q <= 1'b0;
            cod_q <= 1'b0;
        end else if (own_i) begin
            mio_q <= mio_i;
            cod_q <= cod_i;
        end
    end

    // Select between pass-through and hold-time values for every group.
    always_comb begin
        stat_n_o  = own_i ? stat_n_i  : '1;
        lock_n_o  = own_i ? lock_n_i  : 1'b1;
        peack_n_o = own_i ? peack_n_i : 1'b1;
        ready_n_o = own_i ? ready_n_i : 1'b1;
        mio_o     = own_i ? mio_i     : mio_q;
        cod_o     = own_i ? cod_i     : cod_q;
    end

    assert_keep_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_i && !$past(own_i)) |-> ($stable(mio_o) && $stable(cod_o)));
endmodule

// File: rtl/bus_hold_arbiter.sv
// Module: top of the local bus hold arbiter.
// Assumes: hold_req_i may be asynchronous; every other input is synchronous
//          to clk. Pad-level floating and keeping are done outside this block.
module bus_hold_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req_i,
    input  logic              cycle_busy_i,
    input  logic              lock_n_i,
    input  logic              ready_n_i,
    input  logic [STAT_W-1:0] stat_n_i,
    input  logic              peack_n_i,
    input  logic              mio_i,
    input  logic              cod_i,
    output logic              hlda_o,
    output logic              hold_active_o,
    output logic              addr_oe_o,
    output logic              data_oe_o,
    output logic [STAT_W-1:0] stat_n_o,
    output logic              lock_n_o,
    output logic              peack_n_o,
    output logic              mio_o,
    output logic              cod_o,
    output logic              ready_n_o
);
    logic req_s, own;

    bha_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(hold_req_i), .sync_o(req_s)
    );

    bha_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_s), .busy_i(cycle_busy_i),
        .lock_n_i(lock_n_i), .hlda_o(hlda_o), .own_o(own)
    );

    bha_outmux #(.STAT_W(STAT_W)) mux_i (
        .clk(clk), .rst_n(rst_n), .own_i(own), .stat_n_i(stat_n_i),
        .lock_n_i(lock_n_i), .peack_n_i(peack_n_i), .mio_i(mio_i), .cod_i(cod_i),
        .ready_n_i(ready_n_i), .stat_n_o(stat_n_o), .lock_n_o(lock_n_o),
        .peack_n_o(peack_n_o), .mio_o(mio_o), .cod_o(cod_o), .ready_n_o(ready_n_o)
    );

    assign hold_active_o = !own;
    assign addr_oe_o     = own;
    assign data_oe_o     = own;

    assert_release_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_o) |-> $past(!addr_oe_o && !data_oe_o));
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> (!addr_oe_o && !data_oe_o));
    assert_reclaim_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe_o) |-> $past(!hlda_o));
    assert_status_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active_o |-> ((&stat_n_o) && lock_n_o && peack_n_o));
    assert_ready_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active_o |-> ready_n_o);
endmodule

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 34;
    // Vector bits: {hold_req, cycle_busy, lock_n, exp_hlda, exp_hold_active}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b00100, 5'b10100, 5'b10100, 5'b10101, 5'b10111, 5'b10111,  // R2 idle
        5'b00111, 5'b00111, 5'b00101, 5'b00100,                      // R6 drop
        5'b11100, 5'b11100, 5'b11100, 5'b11100, 5'b10101, 5'b10111,  // R4 busy
        5'b00111, 5'b00111, 5'b00101, 5'b00100,
        5'b10000, 5'b10000, 5'b10000, 5'b10101, 5'b10111,            // R5 lock
        5'b00111, 5'b00111, 5'b00101, 5'b00100,
        5'b10100, 5'b00100, 5'b00101, 5'b00100, 5'b00100             // R10 pulse
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic hold_req_i = 0, cycle_busy_i = 0, lock_n_i = 1, ready_n_i = 0;
    logic [1:0] stat_n_i = 2'b00;
    logic peack_n_i = 0, mio_i = 0, cod_i = 0;
    logic hlda_o, hold_active_o, addr_oe_o, data_oe_o;
    logic [1:0] stat_n_o;
    logic lock_n_o, peack_n_o, mio_o, cod_o, ready_n_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hold_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req_i(hold_req_i), .cycle_busy_i(cycle_busy_i),
        .lock_n_i(lock_n_i), .ready_n_i(ready_n_i), .stat_n_i(stat_n_i),
        .peack_n_i(peack_n_i), .mio_i(mio_i), .cod_i(cod_i), .hlda_o(hlda_o),
        .hold_active_o(hold_active_o), .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o),
        .stat_n_o(stat_n_o), .lock_n_o(lock_n_o), .peack_n_o(peack_n_o),
        .mio_o(mio_o), .cod_o(cod_o), .ready_n_o(ready_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step();
        check("R1 hlda in reset", hlda_o, 0);
        check("R1 hold_active in reset", hold_active_o, 0);
        check("R1 oe in reset", {addr_oe_o, data_oe_o}, 2'b11);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {hold_req_i, cycle_busy_i, lock_n_i} = VEC[i][4:2];
            step();
            check($sformatf("R2/R3/R6 hlda vec %0d", i), hlda_o, VEC[i][1]);
            check($sformatf("R2 hold_active vec %0d", i), hold_active_o, VEC[i][0]);
            check($sformatf("R6 oe vec %0d", i), {addr_oe_o, data_oe_o},
                  VEC[i][0] ? 0 : 3);
            check($sformatf("R7 status vec %0d", i), {stat_n_o, lock_n_o, peack_n_o},
                  VEC[i][0] ? 4'b1111 : {2'b00, lock_n_i, 1'b0});
            check($sformatf("R9 ready vec %0d", i), ready_n_o, VEC[i][0] ? 1 : 0);
        end

        // R8: select lines keep the last owned level during hold.
        lock_n_i = 1; mio_i = 1; cod_i = 0; hold_req_i = 1;
        repeat (3) step();
        check("R8 hold_active", hold_active_o, 1);
        mio_i = 0; cod_i = 1;
        step();
        check("R8 mio held", mio_o, 1);
        check("R8 cod held", cod_o, 0);
        check("R9 ready masked", ready_n_o, 1);
        hold_req_i = 0;
        repeat (4) step();
        check("R8 mio follows", mio_o, 0);
        check("R8 cod follows", cod_o, 1);

        // R9: pass-through while owned.
        ready_n_i = 1; #1;
        check("R9 ready pass high", ready_n_o, 1);
        ready_n_i = 0; #1;
        check("R9 ready pass low", ready_n_o, 0);

        // R1: reset in the middle of a grant.
        hold_req_i = 1;
        repeat (4) step();
        check("R1 granted before reset", hlda_o, 1);
        rst_n = 0;
        step();
        check("R1 hlda after reset", hlda_o, 0);
        check("R1 oe after reset", {addr_oe_o, data_oe_o}, 2'b11);
        hold_req_i = 0;
        step();
        rst_n = 1;
        step();
        check("R1 stays owned", hold_active_o, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule